// File: doc/BRIEF.md
# Random Word Peripheral

This block gives software a source of 32-bit pseudorandom words over a small register bus. It has four word-wide registers: control, status, output and entropy. A 32-bit linear feedback shift register runs inside the block. Software can fold values into its state by writing the entropy register. Once generation is enabled and the block is awake, the block copies the current generator word into a one-word holding register. It then shows a level of 1 in the status register. Reading the output register returns that word and empties the holder. The next word follows a cycle later.

Software can put the block to sleep with a control bit, and the surrounding chip can do the same with a doze pin. While the block sleeps, the generator holds its state and no word is loaded. The bus has no back-pressure. Every access completes in the cycle it is presented. Read data is combinational from the current register contents, and any side effect of a read takes place at the closing clock edge. `bus_addr` is a word index: 0 is control, 1 is status, 2 is output and 3 is entropy.

Top module: `rng_periph`

## Requirements
- R1: After reset, reads of the control, status and output registers all return 0x00000000. The generator state is the nonzero constant SEED.
- R2: Writing 1 to control bit 0 enables generation. That bit then stays 1, even after later writes of 0, until the next reset.
- R3: Control bit 4 requests sleep. Status bit 4 reads 1 whenever control bit 4 is set or `doze_i` is high, and 0 otherwise. Control bit 4 reads back as written.
- R4: The generator advances once per clock while enabled and awake. The step is next = (s >> 1) XOR (s[0] ? 0xB4BCD35C : 0). The state holds while the block is disabled or asleep.
- R5: Status bits 15:8 hold the output level. The value is 0 when empty and 1 when full. All other status bits besides bit 4 read 0.
- R6: When the level is 0 and the block is enabled and awake, the current generator word is copied into the output register at the next clock and the level becomes 1. While the level is 1, no new word is loaded.
- R7: A read of the output register at level 1 returns the stored word. At that clock edge, both the word and the level are cleared to 0.
- R8: A read of the output register at level 0 returns 0 and changes nothing.
- R9: The entropy register always reads 0. A write to it XORs the written value into the generator state, and in that cycle the write takes the place of a step.
- R10: If an entropy write would leave the generator state all zeros, the state is set to SEED (0x1D872B41) instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| doze_i | input | 1 | External sleep request |
| bus_addr | input | 2 | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |

## Verification
The checker holds several properties on every cycle. The enable bit never falls. The level never exceeds one and is zero whenever the held word is zero-cleared. The generator never reaches the all-zero state and does not move while the block is stopped. A read of a full holder always empties it, and an empty holder always fills on the next edge once the block is running. The exact word sequence needs the bench's reference model to show. So do the effect of an entropy write on later words, the lockup guard, and the way the two sleep sources combine.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned LVL_W   = 8;
  localparam int unsigned LVL_LSB = 8;
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned SLP_BIT = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_OUT  = 2'd2,
    SEL_ENT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int unsigned         W    = 32,
  parameter logic [W-1:0]        POLY = 32'hB4BC_D35C,
  parameter logic [W-1:0]        SEED = 32'h1D87_2B41
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         mix_i,
  input  logic [W-1:0] mix_data_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] stepped;
  logic [W-1:0] mixed;

  always_comb begin
    stepped = {1'b0, state_q[W-1:1]} ^ (state_q[0] ? POLY : '0);
    mixed   = state_q ^ mix_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (mix_i) begin
      state_q <= (mixed == '0) ? SEED : mixed;
    end else if (step_i) begin
      state_q <= stepped;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/rng_holdbuf.sv
module rng_holdbuf #(
  parameter int unsigned W     = 32,
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [W-1:0]     word_i,
  input  logic             take_i,
  output logic [W-1:0]     word_o,
  output logic [LVL_W-1:0] level_o
);
  logic         full_q;
  logic [W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (take_i && full_q) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (load_i && !full_q) begin
      full_q <= 1'b1;
      word_q <= word_i;
    end
  end

  assign word_o  = word_q;
  assign level_o = LVL_W'(full_q);
endmodule

// File: rtl/rng_ctrl_reg.sv
module rng_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic en_bit_i,
  input  logic slp_bit_i,
  input  logic doze_i,
  output logic en_o,
  output logic slp_o,
  output logic sleeping_o
);
  logic en_q;
  logic slp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      slp_q <= 1'b0;
    end else if (wr_i) begin
      en_q  <= en_q | en_bit_i;
      slp_q <= slp_bit_i;
    end
  end

  assign en_o       = en_q;
  assign slp_o      = slp_q;
  assign sleeping_o = slp_q | doze_i;
endmodule

// File: rtl/rng_periph.sv
module rng_periph
  import rng_pkg::*;
#(
  parameter logic [REG_W-1:0] POLY = 32'hB4BC_D35C,
  parameter logic [REG_W-1:0] SEED = 32'h1D87_2B41
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             doze_i,
  input  logic [SEL_W-1:0] bus_addr,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             bus_re,
  output logic [REG_W-1:0] bus_rdata
);
  reg_sel_e         sel;
  logic             wr_ctrl;
  logic             wr_ent;
  logic             rd_out;
  logic             en_q;
  logic             slp_q;
  logic             sleeping;
  logic             running;
  logic [REG_W-1:0] gen_state;
  logic [REG_W-1:0] hold_word;
  logic [LVL_W-1:0] level;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_ctrl = bus_we && (sel == SEL_CTRL);
  assign wr_ent  = bus_we && (sel == SEL_ENT);
  assign rd_out  = bus_re && (sel == SEL_OUT);
  assign running = en_q && !sleeping;

  rng_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_ctrl),
    .en_bit_i   (bus_wdata[EN_BIT]),
    .slp_bit_i  (bus_wdata[SLP_BIT]),
    .doze_i     (doze_i),
    .en_o       (en_q),
    .slp_o      (slp_q),
    .sleeping_o (sleeping)
  );

  rng_lfsr #(
    .W    (REG_W),
    .POLY (POLY),
    .SEED (SEED)
  ) u_lfsr (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (running),
    .mix_i      (wr_ent),
    .mix_data_i (bus_wdata),
    .state_o    (gen_state)
  );

  rng_holdbuf #(
    .W     (REG_W),
    .LVL_W (LVL_W)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (running),
    .word_i  (gen_state),
    .take_i  (rd_out),
    .word_o  (hold_word),
    .level_o (level)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_CTRL: begin
        bus_rdata[EN_BIT]  = en_q;
        bus_rdata[SLP_BIT] = slp_q;
      end
      SEL_STAT: begin
        bus_rdata[LVL_LSB +: LVL_W] = level;
        bus_rdata[SLP_BIT]          = sleeping;
      end
      SEL_OUT:  bus_rdata = (level != '0) ? hold_word : '0;
      SEL_ENT:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rng_periph_chk.sv
module rng_periph_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_out,
  input logic             wr_ent,
  input logic             en,
  input logic             sleeping,
  input logic [LVL_W-1:0] level,
  input logic [W-1:0]     hold,
  input logic [W-1:0]     state
);
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en); // R2

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(1)); // R5

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en && !sleeping) && !wr_ent) |=> (state == $past(state))); // R4

  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && en && !sleeping) |=> (level == LVL_W'(1))); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out && level != '0) |=> (level == '0 && hold == '0)); // R7

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (hold == '0)); // R8

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0); // R10
endmodule

bind rng_periph rng_periph_chk #(
  .W     (rng_pkg::REG_W),
  .LVL_W (rng_pkg::LVL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_out   (rd_out),
  .wr_ent   (wr_ent),
  .en       (en_q),
  .sleeping (sleeping),
  .level    (level),
  .hold     (hold_word),
  .state    (gen_state)
);

// File: tb/rng_periph_bench.sv
module rng_periph_bench;
  localparam logic [31:0] POLY = 32'hB4BC_D35C;
  localparam logic [31:0] SEED = 32'h1D87_2B41;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        doze_i = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rng_periph u_rng_periph (
    .clk       (clk),
    .rst_n     (rst_n),
    .doze_i    (doze_i),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata)
  );

  // Reference model built from the requirements
  logic        m_en, m_slp, m_full;
  logic [31:0] m_state, m_hold;

  function automatic logic [31:0] step(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? POLY : 32'h0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 1'b0; m_slp <= 1'b0; m_full <= 1'b0;
      m_state <= SEED; m_hold <= '0;
    end else begin : model_upd
      logic run;
      logic [31:0] t;
      run = m_en && !(m_slp || doze_i);
      if (bus_we && bus_addr == 2'd0) begin
        m_en  <= m_en | bus_wdata[0];
        m_slp <= bus_wdata[4];
      end
      t = m_state ^ bus_wdata;
      if (bus_we && bus_addr == 2'd3) m_state <= (t == 0) ? SEED : t;
      else if (run) m_state <= step(m_state);
      if (bus_re && bus_addr == 2'd2 && m_full) begin
        m_full <= 1'b0; m_hold <= '0;
      end else if (!m_full && run) begin
        m_full <= 1'b1; m_hold <= m_state;
      end
    end
  end

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {27'd0, m_slp, 3'd0, m_en};
      2'd1:    return {16'd0, 7'd0, m_full, 3'd0, (m_slp | doze_i), 4'd0};
      2'd2:    return m_full ? m_hold : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  // Scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input string tag);
    bus_addr = a; bus_re = 1'b1; bus_we = 1'b0;
    exp_q.push_back(exp_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    #5;
    if (rst_n && bus_re) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s got %h expected none queued", "scoreboard", bus_rdata);
      end else begin : cmp
        logic [31:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s got %h expected %h", tg, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bus_read(2'd0, "R1 ctrl after reset");
    bus_read(2'd1, "R1 status after reset");
    bus_read(2'd2, "R8 empty output read");
    bus_read(2'd1, "R8 level untouched by empty read");
    // R9 entropy write-only, mix before enable
    bus_write(2'd3, 32'h5A5A_0F0F);
    bus_read(2'd3, "R9 entropy reads zero");
    // enable and first word
    bus_write(2'd0, 32'h1);
    idle(2);
    bus_read(2'd1, "R5 status level one");
    bus_read(2'd2, "R6 first word");
    bus_read(2'd1, "R7 level cleared by read");
    for (int i = 0; i < 4; i++) begin
      idle(1);
      bus_read(2'd2, "R4 word sequence");
    end
    bus_read(2'd2, "R7 back-to-back word");
    bus_read(2'd2, "R7 second read empty");
    // R2 sticky enable
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, "R2 enable sticky");
    // R3 sleep via control
    bus_write(2'd0, 32'h11);
    bus_read(2'd1, "R3 control sleep in status");
    bus_read(2'd0, "R3 control readback");
    bus_read(2'd2, "R7 take word entering sleep");
    idle(5);
    bus_read(2'd1, "R6 no load while asleep");
    bus_read(2'd2, "R8 empty read while asleep");
    // R10 lockup guard: frozen state XOR itself
    bus_write(2'd3, m_state);
    bus_write(2'd0, 32'h1);
    idle(2);
    bus_read(2'd2, "R10 word after zero mix");
    idle(1);
    bus_read(2'd2, "R10 following word");
    // R3 doze pin
    doze_i = 1'b1;
    idle(1);
    bus_read(2'd1, "R3 doze in status");
    bus_read(2'd0, "R3 doze not in control");
    bus_read(2'd2, "R7 take word under doze");
    idle(4);
    bus_read(2'd1, "R4 frozen under doze");
    doze_i = 1'b0;
    idle(2);
    bus_read(2'd2, "R4 resume after doze");
    // R9 mixing while running
    bus_write(2'd3, 32'hDEAD_BEEF);
    idle(1);
    bus_read(2'd2, "R9 word after mix");
    idle(1);
    bus_read(2'd2, "R9 next word after mix");
    idle(3);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard got %0d pending expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule